// File: doc/BRIEF.md
# Pipeline Forwarding and Hazard Controller

This block is the purely combinational hazard logic of a five-stage, in-order pipeline in which conditional branches and register-indirect jumps are resolved in the decode stage. It looks at the register indices held in the decode and execute stages, at the destination index, write enable and load flag carried by the three later pipeline registers, and at the decode-stage next-PC choice with the comparator outcome. From these it produces bypass selects for the decode comparator, for both ALU operands and for store data in the memory stage, plus one control code for each of the IF/ID, ID/EX and EX/MEM pipeline registers.

Each pipeline register obeys a three-way code: 0 advances it, 1 loads a bubble, 2 keeps its contents. The PC is expected to follow the IF/ID code: it holds whenever IF/ID holds. A stall keeps the instruction in decode by holding IF/ID and the PC, loads a bubble into ID/EX and lets EX/MEM advance. A taken branch or a jump with no stall pending loads a bubble into IF/ID, discarding the instruction fetched behind it.

Top module: `hazard_ctrl`

## Requirements
- R1: Each ALU operand select is 2 bits: 0 keeps the register value, 1 takes the EX/MEM ALU result, 2 takes the writeback data. When EX/MEM and MEM/WB both match the execute source index, 1 wins. Code 3 never appears.
- R2: No select forwards from a producer whose write enable is low or whose destination index is 0.
- R3: An ALU operand select is 0 whenever its source flag picks the shift amount (operand A) or the immediate (operand B), even if a producer matches.
- R4: The store-data select is 1 exactly when MEM/WB writes a nonzero index equal to the store's rt field in EX/MEM, and 0 otherwise.
- R5: The decode comparator selects for rs and rt use the same encoding and priority as R1, matched against the decode-stage indices.
- R6: A load in ID/EX with write enable set whose nonzero destination equals the decode rs or rt gives the stall codes IF/ID=2, ID/EX=1, EX/MEM=0. The same producer without the load flag causes no stall for a sequential instruction.
- R7: With next-PC choice 1 (conditional branch, uses rs and rt) or 3 (register jump, uses rs only), a write-enabled ID/EX producer of a used nonzero operand gives the stall codes. The rt field does not stall a register jump.
- R8: With next-PC choice 1 or 3, a load in EX/MEM producing a used operand gives the stall codes. Once that load sits in MEM/WB there is no stall and the decode select is 2. A load in EX/MEM does not stall a sequential instruction.
- R9: Next-PC choice 2 or 3, or choice 1 with the branch outcome true, with no stall gives IF/ID=1, ID/EX=0, EX/MEM=0.
- R10: With no hazard and no redirect (choice 0, or choice 1 not taken), all three codes are 0.
- R11: A stall overrides a redirect: IF/ID is held, never cleared, while a stall is pending. ID/EX is never held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs_i | input | REG_AW | rs index of the instruction in decode |
| id_rt_i | input | REG_AW | rt index of the instruction in decode |
| id_npc_sel_i | input | 2 | Decode next-PC choice: 0 sequential, 1 conditional branch, 2 direct jump, 3 register jump |
| id_br_taken_i | input | 1 | Decode comparator outcome |
| idex_wen_i | input | 1 | ID/EX instruction writes a register |
| idex_rd_i | input | REG_AW | ID/EX destination index |
| idex_load_i | input | 1 | ID/EX instruction is a load |
| ex_rs_i | input | REG_AW | rs index in execute |
| ex_rt_i | input | REG_AW | rt index in execute |
| ex_a_shamt_i | input | 1 | ALU operand A taken from the shift amount |
| ex_b_imm_i | input | 1 | ALU operand B taken from the immediate |
| exmem_wen_i | input | 1 | EX/MEM instruction writes a register |
| exmem_rd_i | input | REG_AW | EX/MEM destination index |
| exmem_load_i | input | 1 | EX/MEM instruction is a load |
| mem_st_rt_i | input | REG_AW | rt index of the instruction in the memory stage |
| memwb_wen_i | input | 1 | MEM/WB instruction writes a register |
| memwb_rd_i | input | REG_AW | MEM/WB destination index |
| id_a_sel_o | output | 2 | Decode comparator rs bypass select |
| id_b_sel_o | output | 2 | Decode comparator rt bypass select |
| ex_a_sel_o | output | 2 | ALU operand A bypass select |
| ex_b_sel_o | output | 2 | ALU operand B bypass select |
| mem_st_sel_o | output | 1 | Store data from writeback |
| ifid_op_o | output | 2 | IF/ID control code (PC follows it) |
| idex_op_o | output | 2 | ID/EX control code |
| exmem_op_o | output | 2 | EX/MEM control code |

## Verification
Every result of this block is due in the same cycle as its stimulus, since no register lies between any input and any output. The bench applies each input pattern at a falling clock edge and samples all outputs one nanosecond later, well before the next rising edge, so every check sees the settled combinational value. Stall and redirect codes are judged as whole triples from a single pattern, and the load-in-flight sequence of R8 is modelled by presenting the load first in EX/MEM and then in MEM/WB on successive patterns.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

   typedef enum logic [1:0] {
      FWD_NONE = 2'd0,
      FWD_MID  = 2'd1,
      FWD_LATE = 2'd2
   } fwd_sel_e;

   typedef enum logic [1:0] {
      PR_RUN    = 2'd0,
      PR_BUBBLE = 2'd1,
      PR_HOLD   = 2'd2
   } preg_op_e;

   typedef enum logic [1:0] {
      NPC_SEQ    = 2'd0,
      NPC_BRANCH = 2'd1,
      NPC_JUMP   = 2'd2,
      NPC_JREG   = 2'd3
   } npc_sel_e;

endpackage

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
   import hazard_pkg::*;
#(
   parameter int AW = 5
) (
   input  logic [AW-1:0] src_i,
   input  logic          bypass_i,
   input  logic          mid_wen_i,
   input  logic [AW-1:0] mid_rd_i,
   input  logic          late_wen_i,
   input  logic [AW-1:0] late_rd_i,
   output logic [1:0]    sel_o
);

   logic mid_hit;
   logic late_hit;

   assign mid_hit  = mid_wen_i  && (mid_rd_i  != '0) && (mid_rd_i  == src_i);
   assign late_hit = late_wen_i && (late_rd_i != '0) && (late_rd_i == src_i);

   always_comb begin
      if (bypass_i)      sel_o = FWD_NONE;
      else if (mid_hit)  sel_o = FWD_MID;
      else if (late_hit) sel_o = FWD_LATE;
      else               sel_o = FWD_NONE;
   end

endmodule

// File: rtl/hz_stall_detect.sv
module hz_stall_detect
   import hazard_pkg::*;
#(
   parameter int AW = 5
) (
   input  logic [AW-1:0] id_rs_i,
   input  logic [AW-1:0] id_rt_i,
   input  logic [1:0]    npc_sel_i,
   input  logic          idex_wen_i,
   input  logic [AW-1:0] idex_rd_i,
   input  logic          idex_load_i,
   input  logic          exmem_wen_i,
   input  logic [AW-1:0] exmem_rd_i,
   input  logic          exmem_load_i,
   output logic          stall_o
);

   logic use_rs, use_rt;
   logic idex_rs_hit, idex_rt_hit;
   logic ldmem_rs_hit, ldmem_rt_hit;
   logic load_use, ctrl_dep;

   // Operands read by the decode-stage comparator or jump target path
   assign use_rs = (npc_sel_i == NPC_BRANCH) || (npc_sel_i == NPC_JREG);
   assign use_rt = (npc_sel_i == NPC_BRANCH);

   assign idex_rs_hit = idex_wen_i && (idex_rd_i != '0) && (idex_rd_i == id_rs_i);
   assign idex_rt_hit = idex_wen_i && (idex_rd_i != '0) && (idex_rd_i == id_rt_i);

   assign ldmem_rs_hit = exmem_load_i && exmem_wen_i && (exmem_rd_i != '0) && (exmem_rd_i == id_rs_i);
   assign ldmem_rt_hit = exmem_load_i && exmem_wen_i && (exmem_rd_i != '0) && (exmem_rd_i == id_rt_i);

   // ALU consumer behind a load: one bubble
   assign load_use = idex_load_i && (idex_rs_hit || idex_rt_hit);

   // Decode-resolved consumer: wait for ID/EX result, and for loads until writeback
   assign ctrl_dep = (use_rs && (idex_rs_hit || ldmem_rs_hit)) ||
                     (use_rt && (idex_rt_hit || ldmem_rt_hit));

   assign stall_o = load_use || ctrl_dep;

endmodule

// File: rtl/hz_preg_ctrl.sv
module hz_preg_ctrl
   import hazard_pkg::*;
(
   input  logic       stall_i,
   input  logic [1:0] npc_sel_i,
   input  logic       br_taken_i,
   output logic [1:0] ifid_op_o,
   output logic [1:0] idex_op_o,
   output logic [1:0] exmem_op_o
);

   logic redirect;

   assign redirect = (npc_sel_i == NPC_JUMP) || (npc_sel_i == NPC_JREG) ||
                     ((npc_sel_i == NPC_BRANCH) && br_taken_i);

   always_comb begin
      ifid_op_o  = PR_RUN;
      idex_op_o  = PR_RUN;
      exmem_op_o = PR_RUN;
      if (stall_i) begin
         // stall before execute: hold PC and IF/ID, bubble into ID/EX
         ifid_op_o = PR_HOLD;
         idex_op_o = PR_BUBBLE;
      end else if (redirect) begin
         ifid_op_o = PR_BUBBLE;
      end
   end

endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
   import hazard_pkg::*;
#(
   parameter int REG_AW = 5
) (
   input  logic [REG_AW-1:0] id_rs_i,
   input  logic [REG_AW-1:0] id_rt_i,
   input  logic [1:0]        id_npc_sel_i,
   input  logic              id_br_taken_i,
   input  logic              idex_wen_i,
   input  logic [REG_AW-1:0] idex_rd_i,
   input  logic              idex_load_i,
   input  logic [REG_AW-1:0] ex_rs_i,
   input  logic [REG_AW-1:0] ex_rt_i,
   input  logic              ex_a_shamt_i,
   input  logic              ex_b_imm_i,
   input  logic              exmem_wen_i,
   input  logic [REG_AW-1:0] exmem_rd_i,
   input  logic              exmem_load_i,
   input  logic [REG_AW-1:0] mem_st_rt_i,
   input  logic              memwb_wen_i,
   input  logic [REG_AW-1:0] memwb_rd_i,
   output logic [1:0]        id_a_sel_o,
   output logic [1:0]        id_b_sel_o,
   output logic [1:0]        ex_a_sel_o,
   output logic [1:0]        ex_b_sel_o,
   output logic              mem_st_sel_o,
   output logic [1:0]        ifid_op_o,
   output logic [1:0]        idex_op_o,
   output logic [1:0]        exmem_op_o
);

   localparam int NUM_OPS = 2;

   if (REG_AW < 2) begin : g_bad_aw
      $error("hazard_ctrl: REG_AW must be at least 2");
   end

   logic [REG_AW-1:0] dec_src [NUM_OPS];
   logic [REG_AW-1:0] ex_src  [NUM_OPS];
   logic              ex_byp  [NUM_OPS];
   logic [1:0]        dec_sel [NUM_OPS];
   logic [1:0]        ex_sel  [NUM_OPS];
   logic              stall;

   assign dec_src[0] = id_rs_i;
   assign dec_src[1] = id_rt_i;
   assign ex_src[0]  = ex_rs_i;
   assign ex_src[1]  = ex_rt_i;
   assign ex_byp[0]  = ex_a_shamt_i;
   assign ex_byp[1]  = ex_b_imm_i;

   for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
      hz_fwd_pick #(.AW(REG_AW)) u_dec_pick (
         .src_i      (dec_src[g]),
         .bypass_i   (1'b0),
         .mid_wen_i  (exmem_wen_i),
         .mid_rd_i   (exmem_rd_i),
         .late_wen_i (memwb_wen_i),
         .late_rd_i  (memwb_rd_i),
         .sel_o      (dec_sel[g])
      );
      hz_fwd_pick #(.AW(REG_AW)) u_ex_pick (
         .src_i      (ex_src[g]),
         .bypass_i   (ex_byp[g]),
         .mid_wen_i  (exmem_wen_i),
         .mid_rd_i   (exmem_rd_i),
         .late_wen_i (memwb_wen_i),
         .late_rd_i  (memwb_rd_i),
         .sel_o      (ex_sel[g])
      );
   end

   assign id_a_sel_o = dec_sel[0];
   assign id_b_sel_o = dec_sel[1];
   assign ex_a_sel_o = ex_sel[0];
   assign ex_b_sel_o = ex_sel[1];

   // store data in the memory stage takes the value being written back
   assign mem_st_sel_o = memwb_wen_i && (memwb_rd_i != '0) && (memwb_rd_i == mem_st_rt_i);

   hz_stall_detect #(.AW(REG_AW)) u_stall (
      .id_rs_i      (id_rs_i),
      .id_rt_i      (id_rt_i),
      .npc_sel_i    (id_npc_sel_i),
      .idex_wen_i   (idex_wen_i),
      .idex_rd_i    (idex_rd_i),
      .idex_load_i  (idex_load_i),
      .exmem_wen_i  (exmem_wen_i),
      .exmem_rd_i   (exmem_rd_i),
      .exmem_load_i (exmem_load_i),
      .stall_o      (stall)
   );

   hz_preg_ctrl u_preg (
      .stall_i    (stall),
      .npc_sel_i  (id_npc_sel_i),
      .br_taken_i (id_br_taken_i),
      .ifid_op_o  (ifid_op_o),
      .idex_op_o  (idex_op_o),
      .exmem_op_o (exmem_op_o)
   );

endmodule

// File: rtl/hazard_ctrl_chk.sv
module hazard_ctrl_chk #(
   parameter int REG_AW = 5
) (
   input logic [1:0]        id_npc_sel_i,
   input logic              id_br_taken_i,
   input logic              ex_a_shamt_i,
   input logic              ex_b_imm_i,
   input logic              exmem_wen_i,
   input logic [REG_AW-1:0] exmem_rd_i,
   input logic [REG_AW-1:0] mem_st_rt_i,
   input logic              memwb_wen_i,
   input logic [REG_AW-1:0] memwb_rd_i,
   input logic [1:0]        id_a_sel_o,
   input logic [1:0]        ex_a_sel_o,
   input logic [1:0]        ex_b_sel_o,
   input logic              mem_st_sel_o,
   input logic [1:0]        ifid_op_o,
   input logic [1:0]        idex_op_o,
   input logic [1:0]        exmem_op_o
);

   always_comb begin
      assert_sel_code_R1: assert (ex_a_sel_o != 2'd3 && ex_b_sel_o != 2'd3 && id_a_sel_o != 2'd3);
      assert_mid_src_R2: assert (ex_a_sel_o != 2'd1 || (exmem_wen_i && exmem_rd_i != '0));
      assert_late_src_R2: assert (ex_b_sel_o != 2'd2 || (memwb_wen_i && memwb_rd_i != '0));
      assert_bypass_a_R3: assert (!ex_a_shamt_i || ex_a_sel_o == 2'd0);
      assert_bypass_b_R3: assert (!ex_b_imm_i || ex_b_sel_o == 2'd0);
      assert_store_src_R4: assert (!mem_st_sel_o || (memwb_wen_i && memwb_rd_i == mem_st_rt_i));
      assert_stall_shape_R6: assert (ifid_op_o != 2'd2 || (idex_op_o == 2'd1 && exmem_op_o == 2'd0));
      assert_redirect_R9: assert (ifid_op_o != 2'd1 ||
                                  (idex_op_o == 2'd0 && (id_npc_sel_i[1] || (id_npc_sel_i == 2'd1 && id_br_taken_i))));
      assert_codes_R11: assert (ifid_op_o != 2'd3 && idex_op_o != 2'd2 && idex_op_o != 2'd3);
   end

endmodule

bind hazard_ctrl hazard_ctrl_chk #(.REG_AW(REG_AW)) u_chk (
   .id_npc_sel_i  (id_npc_sel_i),
   .id_br_taken_i (id_br_taken_i),
   .ex_a_shamt_i  (ex_a_shamt_i),
   .ex_b_imm_i    (ex_b_imm_i),
   .exmem_wen_i   (exmem_wen_i),
   .exmem_rd_i    (exmem_rd_i),
   .mem_st_rt_i   (mem_st_rt_i),
   .memwb_wen_i   (memwb_wen_i),
   .memwb_rd_i    (memwb_rd_i),
   .id_a_sel_o    (id_a_sel_o),
   .ex_a_sel_o    (ex_a_sel_o),
   .ex_b_sel_o    (ex_b_sel_o),
   .mem_st_sel_o  (mem_st_sel_o),
   .ifid_op_o     (ifid_op_o),
   .idex_op_o     (idex_op_o),
   .exmem_op_o    (exmem_op_o)
);

// File: tb/hazard_ctrl_test.sv
`timescale 1ns / 1ps
module hazard_ctrl_test;

   localparam int AW = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [AW-1:0] id_rs, id_rt, idex_rd, ex_rs, ex_rt, exmem_rd, mem_st_rt, memwb_rd;
   logic [1:0]    npc_sel;
   logic          br_taken, idex_wen, idex_load, a_shamt, b_imm;
   logic          exmem_wen, exmem_load, memwb_wen;
   logic [1:0]    id_a_sel, id_b_sel, ex_a_sel, ex_b_sel, ifid_op, idex_op, exmem_op;
   logic          st_sel;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 0;

   hazard_ctrl #(.REG_AW(AW)) uut (
      .id_rs_i       (id_rs),
      .id_rt_i       (id_rt),
      .id_npc_sel_i  (npc_sel),
      .id_br_taken_i (br_taken),
      .idex_wen_i    (idex_wen),
      .idex_rd_i     (idex_rd),
      .idex_load_i   (idex_load),
      .ex_rs_i       (ex_rs),
      .ex_rt_i       (ex_rt),
      .ex_a_shamt_i  (a_shamt),
      .ex_b_imm_i    (b_imm),
      .exmem_wen_i   (exmem_wen),
      .exmem_rd_i    (exmem_rd),
      .exmem_load_i  (exmem_load),
      .mem_st_rt_i   (mem_st_rt),
      .memwb_wen_i   (memwb_wen),
      .memwb_rd_i    (memwb_rd),
      .id_a_sel_o    (id_a_sel),
      .id_b_sel_o    (id_b_sel),
      .ex_a_sel_o    (ex_a_sel),
      .ex_b_sel_o    (ex_b_sel),
      .mem_st_sel_o  (st_sel),
      .ifid_op_o     (ifid_op),
      .idex_op_o     (idex_op),
      .exmem_op_o    (exmem_op)
   );

   task automatic idle();
      id_rs = '0; id_rt = '0; npc_sel = 2'd0; br_taken = 1'b0;
      idex_wen = 1'b0; idex_rd = '0; idex_load = 1'b0;
      ex_rs = '0; ex_rt = '0; a_shamt = 1'b0; b_imm = 1'b0;
      exmem_wen = 1'b0; exmem_rd = '0; exmem_load = 1'b0;
      mem_st_rt = '0; memwb_wen = 1'b0; memwb_rd = '0;
   endtask

   // apply at the falling edge, sample 1 ns later (outputs are combinational)
   task automatic settle();
      @(negedge clk);
      #1;
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic chk_codes(input string req, input int e_ifid, input int e_idex, input int e_exmem);
      chk(req, "ifid_op", int'(ifid_op), e_ifid);
      chk(req, "idex_op", int'(idex_op), e_idex);
      chk(req, "exmem_op", int'(exmem_op), e_exmem);
   endtask

   task automatic t_reset_idle();
      idle();
      wait (rst_n);
      settle();
      chk("R10", "idle ex_a_sel", int'(ex_a_sel), 0);
      chk("R10", "idle id_a_sel", int'(id_a_sel), 0);
      chk("R10", "idle st_sel", int'(st_sel), 0);
      chk_codes("R10", 0, 0, 0);
   endtask

   task automatic t_ex_forward();
      idle();
      ex_rs = 5'd3; exmem_wen = 1'b1; exmem_rd = 5'd3;
      ex_rt = 5'd4; memwb_wen = 1'b1; memwb_rd = 5'd4;
      settle();
      chk("R1", "ex_a_sel from EX/MEM", int'(ex_a_sel), 1);
      chk("R1", "ex_b_sel from MEM/WB", int'(ex_b_sel), 2);
      idle();
      ex_rs = 5'd5; ex_rt = 5'd5; exmem_wen = 1'b1; exmem_rd = 5'd5;
      memwb_wen = 1'b1; memwb_rd = 5'd5;
      settle();
      chk("R1", "priority a", int'(ex_a_sel), 1);
      chk("R1", "priority b", int'(ex_b_sel), 1);
   endtask

   task automatic t_no_forward();
      idle();
      ex_rs = 5'd0; exmem_wen = 1'b1; exmem_rd = 5'd0;
      ex_rt = 5'd0; memwb_wen = 1'b1; memwb_rd = 5'd0;
      settle();
      chk("R2", "reg0 a", int'(ex_a_sel), 0);
      chk("R2", "reg0 b", int'(ex_b_sel), 0);
      idle();
      ex_rs = 5'd6; exmem_rd = 5'd6; ex_rt = 5'd7; memwb_rd = 5'd7;
      settle();
      chk("R2", "wen low a", int'(ex_a_sel), 0);
      chk("R2", "wen low b", int'(ex_b_sel), 0);
   endtask

   task automatic t_bypass();
      idle();
      ex_rs = 5'd3; ex_rt = 5'd4; exmem_wen = 1'b1; exmem_rd = 5'd3;
      memwb_wen = 1'b1; memwb_rd = 5'd4; a_shamt = 1'b1; b_imm = 1'b1;
      settle();
      chk("R3", "shamt a", int'(ex_a_sel), 0);
      chk("R3", "imm b", int'(ex_b_sel), 0);
      a_shamt = 1'b0;
      settle();
      chk("R3", "a restored", int'(ex_a_sel), 1);
   endtask

   task automatic t_store();
      idle();
      mem_st_rt = 5'd7; memwb_wen = 1'b1; memwb_rd = 5'd7;
      settle();
      chk("R4", "store match", int'(st_sel), 1);
      memwb_rd = 5'd6;
      settle();
      chk("R4", "store index differs", int'(st_sel), 0);
      memwb_rd = 5'd7; memwb_wen = 1'b0;
      settle();
      chk("R4", "store wen low", int'(st_sel), 0);
      mem_st_rt = 5'd0; memwb_rd = 5'd0; memwb_wen = 1'b1;
      settle();
      chk("R4", "store reg0", int'(st_sel), 0);
   endtask

   task automatic t_dec_forward();
      idle();
      npc_sel = 2'd1; br_taken = 1'b0;
      id_rs = 5'd8; exmem_wen = 1'b1; exmem_rd = 5'd8;
      id_rt = 5'd9; memwb_wen = 1'b1; memwb_rd = 5'd9;
      settle();
      chk("R5", "id_a_sel EX/MEM", int'(id_a_sel), 1);
      chk("R5", "id_b_sel MEM/WB", int'(id_b_sel), 2);
      chk_codes("R10", 0, 0, 0);
   endtask

   task automatic t_load_use();
      idle();
      id_rt = 5'd10; idex_wen = 1'b1; idex_rd = 5'd10; idex_load = 1'b1;
      settle();
      chk_codes("R6", 2, 1, 0);
      idex_load = 1'b0;
      settle();
      chk_codes("R6", 0, 0, 0);
   endtask

   task automatic t_branch_dep();
      idle();
      npc_sel = 2'd1; br_taken = 1'b1; id_rs = 5'd11;
      idex_wen = 1'b1; idex_rd = 5'd11;
      settle();
      chk_codes("R7", 2, 1, 0);
      chk("R11", "no flush under stall", int'(ifid_op), 2);
      idle();
      npc_sel = 2'd3; id_rs = 5'd11; idex_wen = 1'b1; idex_rd = 5'd11;
      settle();
      chk_codes("R7", 2, 1, 0);
      idle();
      npc_sel = 2'd3; id_rs = 5'd2; id_rt = 5'd11; idex_wen = 1'b1; idex_rd = 5'd11;
      settle();
      chk_codes("R7", 1, 0, 0);
   endtask

   task automatic t_branch_load();
      idle();
      npc_sel = 2'd1; br_taken = 1'b1; id_rs = 5'd12;
      exmem_wen = 1'b1; exmem_rd = 5'd12; exmem_load = 1'b1;
      settle();
      chk_codes("R8", 2, 1, 0);
      exmem_wen = 1'b0; exmem_rd = 5'd0; exmem_load = 1'b0;
      memwb_wen = 1'b1; memwb_rd = 5'd12;
      settle();
      chk("R8", "id_a_sel after load", int'(id_a_sel), 2);
      chk_codes("R8", 1, 0, 0);
      idle();
      id_rs = 5'd12; exmem_wen = 1'b1; exmem_rd = 5'd12; exmem_load = 1'b1;
      settle();
      chk_codes("R8", 0, 0, 0);
   endtask

   task automatic t_redirect();
      idle();
      npc_sel = 2'd2;
      settle();
      chk_codes("R9", 1, 0, 0);
      npc_sel = 2'd3;
      settle();
      chk_codes("R9", 1, 0, 0);
      npc_sel = 2'd1; br_taken = 1'b1;
      settle();
      chk_codes("R9", 1, 0, 0);
      br_taken = 1'b0;
      settle();
      chk_codes("R10", 0, 0, 0);
   endtask

   initial begin
      idle();
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      t_reset_idle();
      t_ex_forward();
      t_no_forward();
      t_bypass();
      t_store();
      t_dec_forward();
      t_load_use();
      t_branch_dep();
      t_branch_load();
      t_redirect();
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule